// File: doc/BRIEF.md
# Debug Address Match Unit

This block is a debug comparator that sits beside a CPU core. It watches the instruction fetch address and the data access address. When an access meets a condition that software has programmed, it raises a halt request. All state sits in one 32-bit control word that software writes and reads through a plain register port. The word holds three match enables, a sticky hit flag, a mask count for data matches and a 24-bit match address.

Program-counter matches always compare the full address. Data read and write matches can ignore a number of low address bits, from 0 to 15. One entry can therefore guard an aligned block of up to 32K bytes.

When a programmed condition matches, the unit pulses `break_req` for one clock and sets the hit flag. The flag stays set until software writes 0 to it. Software can also set the flag directly by writing 1 to it.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `break_req` and `hit_status` are 0.
- R2: A register write stores `reg_wdata` into the control word, which `reg_rdata` returns on the next cycle. The field layout is: bit 31 is the PC match enable, bit 30 is the hit flag, bit 29 is the read match enable, bit 28 is the write match enable, bits 27:24 are the mask count, and bits 23:0 are the match address. `hit_status` always equals bit 30.
- R3: When the PC enable is 1, `fetch_valid` is 1 and `fetch_addr` equals all 24 bits of the match address, `break_req` is 1 on the next cycle. The mask count never applies to this compare.
- R4: When the read enable is 1 and `data_rd` is 1, the access matches if `data_addr` and the match address agree in every bit except the N lowest, where N is the mask count (0 to 15). A match makes `break_req` 1 on the next cycle.
- R5: When the write enable is 1 and `data_wr` is 1, the access is matched with the same masked rule as in R4. The read and write enables act independently of each other.
- R6: A condition whose enable is 0 never causes `break_req`, and it never sets the hit flag.
- R7: Any match sets the hit flag on the same clock edge that raises `break_req`. The flag then holds at 1 for as long as no register write occurs.
- R8: A register write with bit 30 set to 1 sets the hit flag. A register write with bit 30 set to 0 clears it.
- R9: When a match and a register write that clears bit 30 occur in the same cycle, the hit flag ends at 1.
- R10: `break_req` is high for exactly the cycles that follow a matching cycle. When the access is not repeated, it is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 24 | Instruction fetch address |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| data_addr | input | 24 | Data access address |
| break_req | output | 1 | Halt request pulse |
| hit_status | output | 1 | Sticky hit flag |

## Verification
Every result appears one clock after the cycle in which its stimulus is presented. This holds for `break_req`, for the hit flag and for the readback of a written field. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and the outputs are compared with the model on the next falling edge, half a cycle after the register update. The reset state is checked once, before any stimulus is applied. All remaining checks are made cycle by cycle against the model.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
    parameter int ADDR_W = 24;
    parameter int CNT_W  = 4;
    parameter int WORD_W = 32;

    typedef struct packed {
        logic              pc_en;
        logic              hit;
        logic              rd_en;
        logic              wr_en;
        logic [CNT_W-1:0]  mask_cnt;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic brk;
    } state_t;
endpackage

// File: rtl/dbg_mask_gen.sv
module dbg_mask_gen #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4
) (
    input  logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] keep
);
    // A bit takes part in the compare when its index is at or above the count.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign keep[i] = (i >= int'(cnt));
    end
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    input  logic [ADDR_W-1:0] keep,
    output logic              eq
);
    assign eq = ~|((a ^ b) & keep);
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              break_req,
    output logic              hit_status
);
    localparam logic [ADDR_W-1:0] FULL_KEEP = '1;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] data_keep;
    logic              pc_eq, data_eq;
    logic              any_hit;

    dbg_mask_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mask (
        .cnt  (st_q.ctl.mask_cnt),
        .keep (data_keep)
    );

    dbg_addr_cmp #(.ADDR_W(ADDR_W)) u_pc_cmp (
        .a    (fetch_addr),
        .b    (st_q.ctl.addr),
        .keep (FULL_KEEP),
        .eq   (pc_eq)
    );

    dbg_addr_cmp #(.ADDR_W(ADDR_W)) u_data_cmp (
        .a    (data_addr),
        .b    (st_q.ctl.addr),
        .keep (data_keep),
        .eq   (data_eq)
    );

    always_comb begin
        st_d    = st_q;
        any_hit = (st_q.ctl.pc_en && fetch_valid && pc_eq)
               || (st_q.ctl.rd_en && data_rd && data_eq)
               || (st_q.ctl.wr_en && data_wr && data_eq);
        if (reg_wr_en) begin
            st_d.ctl = ctl_t'(reg_wdata);
        end
        if (any_hit) begin
            st_d.ctl.hit = 1'b1;
        end
        st_d.brk = any_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = st_q.ctl;
    assign break_req  = st_q.brk;
    assign hit_status = st_q.ctl.hit;
endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk
    import dbg_match_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              data_rd,
    input logic              data_wr,
    input logic [ADDR_W-1:0] data_addr,
    input logic              break_req,
    input logic              hit_status
);
    logic [ADDR_W-1:0] m_addr;
    logic [CNT_W-1:0]  m_cnt;
    logic              m_eq;

    assign m_addr = reg_rdata[ADDR_W-1:0];
    assign m_cnt  = reg_rdata[27:24];
    assign m_eq   = ((data_addr >> m_cnt) == (m_addr >> m_cnt));

    a_r2_flag_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status == reg_rdata[30]);

    a_r3_pc_match: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && fetch_valid && fetch_addr == m_addr) |=> break_req);

    a_r4_rd_match: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[29] && data_rd && m_eq) |=> break_req);

    a_r5_wr_match: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[28] && data_wr && m_eq) |=> break_req);

    a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && !reg_rdata[29] && !reg_rdata[28]) |=> !break_req);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_status && !reg_wr_en) |=> hit_status);

    a_r8_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[30]) |=> hit_status);

    a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> hit_status);
endmodule

bind dbg_match_unit dbg_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .data_rd     (data_rd),
    .data_wr     (data_wr),
    .data_addr   (data_addr),
    .break_req   (break_req),
    .hit_status  (hit_status)
);

// File: tb/dbg_match_unit_tb.sv
`timescale 1ns/1ps
module dbg_match_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        data_rd = 1'b0;
    logic        data_wr = 1'b0;
    logic [23:0] data_addr = '0;
    logic        break_req;
    logic        hit_status;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string cur_req  = "R1";
    bit    run_cmp  = 1'b0;

    // behavioural reference
    bit       m_pc, m_st, m_rd, m_wr, m_brk;
    int       m_cnt;
    bit [23:0] m_addr;

    always #2.5 clk = ~clk;

    dbg_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .data_rd(data_rd), .data_wr(data_wr), .data_addr(data_addr),
        .break_req(break_req), .hit_status(hit_status)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] mk(bit pc, bit st, bit rd, bit wr, int cnt, bit [23:0] a);
        return {pc, st, rd, wr, 4'(cnt), a};
    endfunction

    always @(posedge clk) begin
        bit hit;
        cycles++;
        if (!rst_n) begin
            {m_pc, m_st, m_rd, m_wr, m_brk} = '0;
            m_cnt = 0; m_addr = '0;
        end else begin
            hit = (m_pc && fetch_valid && fetch_addr == m_addr)
               || (m_rd && data_rd && (data_addr >> m_cnt) == (m_addr >> m_cnt))
               || (m_wr && data_wr && (data_addr >> m_cnt) == (m_addr >> m_cnt));
            if (reg_wr_en) begin
                m_pc = reg_wdata[31]; m_st = reg_wdata[30]; m_rd = reg_wdata[29];
                m_wr = reg_wdata[28]; m_cnt = int'(reg_wdata[27:24]); m_addr = reg_wdata[23:0];
            end
            if (hit) m_st = 1'b1;
            m_brk = hit;
        end
    end

    always @(negedge clk) begin
        if (run_cmp) begin
            chk(cur_req, "break_req", 32'(break_req), 32'(m_brk));
            chk(cur_req, "rdata", reg_rdata, {m_pc, m_st, m_rd, m_wr, 4'(m_cnt), m_addr});
            chk("R2", "hit_status", 32'(hit_status), 32'(m_st));
        end
    end

    // one cycle of stimulus, then back to idle next call
    task automatic cyc(bit we, bit [31:0] wd, bit fv, bit [23:0] fa,
                       bit rd, bit wr, bit [23:0] da);
        @(negedge clk);
        reg_wr_en = we; reg_wdata = wd; fetch_valid = fv; fetch_addr = fa;
        data_rd = rd; data_wr = wr; data_addr = da;
    endtask

    task automatic idle();
        cyc(0, '0, 0, '0, 0, 0, '0);
    endtask

    task automatic prog(bit [31:0] w);
        cyc(1, w, 0, '0, 0, 0, '0);
        idle();
    endtask

    initial begin
        #20000000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        bit [23:0] base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "rdata", reg_rdata, 32'h0);
        chk("R1", "break_req", 32'(break_req), 32'h0);
        chk("R1", "hit_status", 32'(hit_status), 32'h0);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        // R6: nothing enabled, accesses at address 0 ignored
        cur_req = "R6";
        cyc(0, '0, 1, 24'h0, 1, 1, 24'h0);
        idle();
        // R2 field readback
        cur_req = "R2";
        prog(mk(0, 0, 0, 0, 9, 24'hC3A55A));
        prog(mk(0, 1, 0, 0, 0, 24'h000000));
        prog(32'h0);
        // R3 PC compare, full width even with mask 15
        cur_req = "R3";
        prog(mk(1, 0, 0, 0, 15, 24'h123456));
        cyc(0, '0, 1, 24'h123457, 0, 0, '0);
        cyc(0, '0, 1, 24'h123456, 0, 0, '0);
        cyc(0, '0, 0, 24'h123456, 0, 0, '0);
        cur_req = "R6";
        cyc(0, '0, 0, '0, 1, 1, 24'h123456);
        idle();
        // R4 mask sweep on reads
        base = 24'h5A8000;
        for (int n = 0; n < 16; n++) begin
            cur_req = "R4";
            prog(mk(0, 0, 1, 0, n, base | 24'((1 << n) >> 1)));
            cyc(0, '0, 0, '0, 1, 0, base);
            cyc(0, '0, 0, '0, 1, 0, base + 24'((1 << n) - 1));
            cyc(0, '0, 0, '0, 1, 0, base + 24'(1 << n));
            cyc(0, '0, 0, '0, 1, 0, base - 24'd1);
            cyc(0, '0, 0, '0, 0, 1, base);
            idle();
        end
        // R5 write-only and both modes
        cur_req = "R5";
        prog(mk(0, 0, 0, 1, 3, 24'h000A40));
        cyc(0, '0, 0, '0, 1, 0, 24'h000A47);
        cyc(0, '0, 0, '0, 0, 1, 24'h000A47);
        cyc(0, '0, 0, '0, 0, 1, 24'h000A48);
        idle();
        prog(mk(0, 0, 1, 1, 3, 24'h000A40));
        cyc(0, '0, 0, '0, 1, 0, 24'h000A41);
        cyc(0, '0, 0, '0, 0, 1, 24'h000A42);
        idle();
        // R7 sticky, R10 pulse
        cur_req = "R7";
        prog(mk(0, 0, 1, 0, 0, 24'h00BEEF));
        cyc(0, '0, 0, '0, 1, 0, 24'h00BEEF);
        cur_req = "R10";
        idle(); idle(); idle();
        cyc(0, '0, 0, '0, 1, 0, 24'h00BEEF);
        cyc(0, '0, 0, '0, 1, 0, 24'h00BEEF);
        idle(); idle();
        // R8 software clear and set
        cur_req = "R8";
        prog(mk(0, 0, 1, 0, 0, 24'h00BEEF));
        prog(mk(0, 1, 0, 0, 0, 24'h00BEEF));
        prog(mk(0, 0, 0, 0, 0, 24'h00BEEF));
        // R9 hit beats software clear
        cur_req = "R9";
        prog(mk(1, 0, 0, 0, 0, 24'h000100));
        cyc(1, mk(1, 0, 0, 0, 0, 24'h000100), 1, 24'h000100, 0, 0, '0);
        idle(); idle();
        run_cmp = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule